// File: doc/BRIEF.md
# SPI Master with Hardware Transfer Sequencer

This block is a register-mapped SPI master. Software writes the frame format, the clock divider and a transfer descriptor: a mode code plus separate write and read byte counts, each stored as count minus one. Any write to the command register then runs the whole framed transfer in hardware. The block asserts chip select, shifts out the bytes queued in a TX FIFO, clocks the returned bytes into an RX FIFO and releases chip select when the last bit is done. Software does not handle chip select or individual bits.

Four modes move data: full duplex, write only, read only, and write then read under a single chip-select window. Two more cases move no data. The sequencer never overruns or underruns its FIFOs. When the TX FIFO is empty and write bytes remain, or when the RX FIFO has no room for the next byte, SCLK is held between bytes until the FIFO can serve the byte. Self-clearing control bits flush either FIFO or abort the shift engine. A status word reports busy, the FIFO levels and the TX empty and full flags.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, status (0x34) reads 0x0040_0000 (only TX-empty set), format (0x10) reads 0x0000_0700, spi_cs_n is 1, spi_sclk is 0 and spi_mosi is 0.
- R2: The transfer control register at 0x20 holds the mode in bits 27:24, the write count minus one in bits 20:12 and the read count minus one in bits 8:0, so each phase carries 1 to 512 bytes. Any write to 0x24 starts a transfer. In mode 1 (write only), exactly the programmed number of bytes leave on MOSI, MSB first, and nothing enters the RX FIFO.
- R3: In mode 2 (read only), the programmed number of bytes are sampled from MISO while MOSI stays 0. Each byte is pushed into the RX FIFO, and each read of the data register at 0x2C returns and removes the oldest byte. A read of an empty RX FIFO returns 0.
- R4: In mode 3 (write then read), the write bytes are followed by the read bytes inside one chip-select low window. MOSI is 0 during the read phase, and only the read-phase bytes enter the RX FIFO.
- R5: In mode 0 (full duplex), each written byte is paired with a byte sampled in the same frame, and the read count field is ignored.
- R6: Mode 7, and every code above 3 other than 7, produces one chip-select pulse with no SCLK edges and no FIFO traffic.
- R7: The timing register at 0x40 holds div in bits 7:0. The SCLK period within a frame is 2*(div+1) system clocks.
- R8: When write bytes remain and the TX FIFO is empty, SCLK stops at its idle level and the transfer stays busy until data is written to 0x2C.
- R9: When a read byte is due and the RX FIFO is full, SCLK stops and the transfer resumes after software pops a byte. No RX data is lost.
- R10: Status bit 0 is busy, bits 12:8 the RX level, bits 20:16 the TX level, bit 22 TX empty and bit 23 TX full. A write to 0x2C while the TX FIFO is full is dropped.
- R11: Control register 0x30: bit 2 flushes the TX FIFO, bit 1 flushes the RX FIFO and bit 0 aborts the shift engine, which releases chip select at once. Each bit reads back as 0 one cycle after it is written.
- R12: A write to 0x24 while busy has no effect. The running transfer is neither restarted nor extended.
- R13: Format bits 12:8 hold the frame length minus one, with values of 7 and above giving 8-bit frames. Bit 1 selects the SCLK idle level (CPOL) and bit 0 selects sampling on the trailing edge (CPHA).
- R14: Chip select rises exactly (div+1) clocks after the last SCLK edge, and busy falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on data reads) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_addr is held |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A wrong byte or phase counter in the sequencer shows up at the pins within one frame. The number of SCLK rising edges inside a chip-select window then differs from 8 times the programmed byte count, or bytes land in the RX FIFO during the wrong phase, and the status level field exposes this on the next read. A broken divider or half-period counter changes the measured SCLK period and the gap from the last edge to chip-select release on the very first bit. A stall decision that is wrong either lets SCLK run with an empty TX FIFO, which is visible as extra edges, or overfills the RX FIFO, which is visible as corrupted or missing bytes when the FIFO is drained.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam logic [7:0] REG_FORMAT = 8'h10;
  localparam logic [7:0] REG_XCTRL  = 8'h20;
  localparam logic [7:0] REG_CMD    = 8'h24;
  localparam logic [7:0] REG_DATA   = 8'h2C;
  localparam logic [7:0] REG_CTRL   = 8'h30;
  localparam logic [7:0] REG_STATUS = 8'h34;
  localparam logic [7:0] REG_TIMING = 8'h40;

  localparam int CNT_W = 9;
  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  typedef enum logic [3:0] {
    XM_DUPLEX = 4'd0,
    XM_WRITE  = 4'd1,
    XM_READ   = 4'd2,
    XM_WR_RD  = 4'd3,
    XM_NONE   = 4'd7
  } xfer_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LOAD,
    SQ_BIT,
    SQ_HOLD
  } seq_state_e;

endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]   lvl_q, lvl_n;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    lvl_n = lvl_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (push) wp_n = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_n = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_n = lvl_q + 1'b1;
        2'b01:   lvl_n = lvl_q - 1'b1;
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign level = lvl_q;
  assign full  = (lvl_q == (AW+1)'(DEPTH));
  assign empty = (lvl_q == '0);

  // R10 / R9: producers never write into a full queue
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: consumers never read from an empty queue
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic [3:0]           mode_i,
  input  logic [CNT_W-1:0]     wcnt_i,
  input  logic [CNT_W-1:0]     rcnt_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 tx_empty_i,
  input  logic [FRAME_W-1:0]   tx_data_i,
  output logic                 tx_pop_o,
  input  logic                 rx_full_i,
  output logic                 rx_push_o,
  output logic [FRAME_W-1:0]   rx_data_o,
  output logic                 sclk_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic                 cs_n_o,
  output logic                 busy_o
);
  localparam int BIT_W = $clog2(FRAME_W);

  seq_state_e          st_q, st_n;
  xfer_mode_e          mode_q, mode_n;
  logic [DIV_W-1:0]    divc_q, divc_n;
  logic                half_q, half_n;
  logic [BIT_W-1:0]    bit_q, bit_n;
  logic [BIT_W-1:0]    len_q, len_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [CNT_W-1:0]    rcnt_q, rcnt_n;
  logic                wph_q, wph_n;
  logic                cpol_q, cpol_n, cpha_q, cpha_n;
  logic [FRAME_W-1:0]  txb_q, txb_n;
  logic [FRAME_W-1:0]  rxsh_q, rxsh_n;
  logic                sclk_q, sclk_n, mosi_q, mosi_n, csn_q, csn_n;

  logic                tick, go, has_data, rd_byte, wr_byte;
  logic [FRAME_W-1:0]  len_mask, sampled;
  xfer_mode_e          mode_in;

  assign tick     = (divc_q == div_i);
  assign go       = start_i && (st_q == SQ_IDLE) && !abort_i;
  assign mode_in  = xfer_mode_e'(mode_i);
  assign has_data = (mode_q == XM_DUPLEX) || (mode_q == XM_WRITE) ||
                    (mode_q == XM_READ)   || (mode_q == XM_WR_RD);
  assign wr_byte  = wph_q;
  assign rd_byte  = !wph_q || (mode_q == XM_DUPLEX);
  assign sampled  = cpha_q ? {rxsh_q[FRAME_W-2:0], miso_i} : rxsh_q;

  always_comb begin
    for (int i = 0; i < FRAME_W; i++) len_mask[i] = (i <= int'(len_q));
  end

  always_comb begin
    st_n = st_q;  mode_n = mode_q; divc_n = divc_q; half_n = half_q;
    bit_n = bit_q; len_n = len_q;  cnt_n = cnt_q;   rcnt_n = rcnt_q;
    wph_n = wph_q; cpol_n = cpol_q; cpha_n = cpha_q;
    txb_n = txb_q; rxsh_n = rxsh_q; sclk_n = sclk_q; mosi_n = mosi_q;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    rx_data_o = sampled & len_mask;

    if (st_q == SQ_SETUP || st_q == SQ_BIT || st_q == SQ_HOLD)
      divc_n = tick ? '0 : divc_q + 1'b1;
    else
      divc_n = '0;

    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          st_n   = SQ_SETUP;
          mode_n = mode_in;
          rcnt_n = rcnt_i;
          wph_n  = (mode_in != XM_READ);
          cnt_n  = (mode_in == XM_READ) ? rcnt_i : wcnt_i;
          cpol_n = cpol_i;
          cpha_n = cpha_i;
          len_n  = (len_i >= LEN_W'(FRAME_W-1)) ? BIT_W'(FRAME_W-1) : len_i[BIT_W-1:0];
        end
      end
      SQ_SETUP: begin
        if (tick) st_n = has_data ? SQ_LOAD : SQ_HOLD;
      end
      SQ_LOAD: begin
        if (!(wr_byte && tx_empty_i) && !(rd_byte && rx_full_i)) begin
          tx_pop_o = wr_byte;
          txb_n    = wr_byte ? tx_data_i : '0;
          bit_n    = len_q;
          half_n   = 1'b0;
          st_n     = SQ_BIT;
          if (!cpha_q) mosi_n = wr_byte ? tx_data_i[len_q] : 1'b0;
        end
      end
      SQ_BIT: begin
        if (tick) begin
          sclk_n = ~sclk_q;
          if (!half_q) begin
            half_n = 1'b1;
            if (cpha_q) mosi_n = txb_q[bit_q];
            else        rxsh_n = {rxsh_q[FRAME_W-2:0], miso_i};
          end else begin
            half_n = 1'b0;
            if (cpha_q) rxsh_n = sampled;
            if (bit_q != '0) begin
              bit_n = bit_q - 1'b1;
              if (!cpha_q) mosi_n = txb_q[bit_q - 1'b1];
            end else begin
              rx_push_o = rd_byte;
              if (cnt_q == '0) begin
                if (wph_q && mode_q == XM_WR_RD) begin
                  wph_n = 1'b0;
                  cnt_n = rcnt_q;
                  st_n  = SQ_LOAD;
                end else begin
                  st_n = SQ_HOLD;
                end
              end else begin
                cnt_n = cnt_q - 1'b1;
                st_n  = SQ_LOAD;
              end
            end
          end
        end
      end
      SQ_HOLD: begin
        if (tick) st_n = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase

    if (abort_i) begin
      st_n      = SQ_IDLE;
      tx_pop_o  = 1'b0;
      rx_push_o = 1'b0;
    end
    if (st_n == SQ_IDLE) begin
      sclk_n = cpol_i;
      mosi_n = 1'b0;
    end
    csn_n = (st_n == SQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;  mode_q <= XM_NONE; divc_q <= '0; half_q <= 1'b0;
      bit_q <= '0;      len_q <= '0;       cnt_q <= '0;  rcnt_q <= '0;
      wph_q <= 1'b0;    cpol_q <= 1'b0;    cpha_q <= 1'b0;
      txb_q <= '0;      rxsh_q <= '0;
      sclk_q <= 1'b0;   mosi_q <= 1'b0;    csn_q <= 1'b1;
    end else begin
      st_q <= st_n;     mode_q <= mode_n;  divc_q <= divc_n; half_q <= half_n;
      bit_q <= bit_n;   len_q <= len_n;    cnt_q <= cnt_n;   rcnt_q <= rcnt_n;
      wph_q <= wph_n;   cpol_q <= cpol_n;  cpha_q <= cpha_n;
      txb_q <= txb_n;   rxsh_q <= rxsh_n;
      sclk_q <= sclk_n; mosi_q <= mosi_n;  csn_q <= csn_n;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign cs_n_o = csn_q;
  assign busy_o = (st_q != SQ_IDLE);

  // R8: an empty TX queue during the write phase freezes SCLK
  assert_tx_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_LOAD && wph_q && tx_empty_i && !abort_i) |=> $stable(sclk_o));
  // R9: a byte is only completed when the RX queue can take it
  assert_rx_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> !rx_full_i);
  // R11: abort releases chip select on the next edge
  assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (cs_n_o && !busy_o));
  // R12: a start request during a transfer leaves the descriptor alone
  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(mode_q) && $stable(rcnt_q)));
  // R13: with chip select released, SCLK sits at the programmed idle level
  assert_idle_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o) && $stable(cpol_i)) |-> (sclk_o == cpol_i));

endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int FRAME_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [LEN_W-1:0] fmt_len_q, fmt_len_n;
  logic             fmt_cpol_q, fmt_cpol_n, fmt_cpha_q, fmt_cpha_n;
  logic [3:0]       xmode_q, xmode_n;
  logic [CNT_W-1:0] wcnt_q, wcnt_n, rcnt_q, rcnt_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [2:0]       ctrl_q, ctrl_n;

  logic wr_fmt, wr_xctrl, wr_cmd, wr_data, wr_ctrl, wr_tim, rd_data;
  assign wr_fmt   = bus_wr && (bus_addr == REG_FORMAT);
  assign wr_xctrl = bus_wr && (bus_addr == REG_XCTRL);
  assign wr_cmd   = bus_wr && (bus_addr == REG_CMD);
  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign wr_tim   = bus_wr && (bus_addr == REG_TIMING);
  assign rd_data  = bus_rd && (bus_addr == REG_DATA);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:28], bus_wdata[23:21]};

  always_comb begin
    fmt_len_n  = wr_fmt ? bus_wdata[12:8] : fmt_len_q;
    fmt_cpol_n = wr_fmt ? bus_wdata[1]    : fmt_cpol_q;
    fmt_cpha_n = wr_fmt ? bus_wdata[0]    : fmt_cpha_q;
    xmode_n    = wr_xctrl ? bus_wdata[27:24] : xmode_q;
    wcnt_n     = wr_xctrl ? bus_wdata[20:12] : wcnt_q;
    rcnt_n     = wr_xctrl ? bus_wdata[8:0]   : rcnt_q;
    div_n      = wr_tim ? bus_wdata[7:0] : div_q;
    ctrl_n     = wr_ctrl ? bus_wdata[2:0] : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fmt_len_q <= LEN_W'(7); fmt_cpol_q <= 1'b0; fmt_cpha_q <= 1'b0;
      xmode_q <= '0; wcnt_q <= '0; rcnt_q <= '0;
      div_q <= '0; ctrl_q <= '0;
    end else begin
      fmt_len_q <= fmt_len_n; fmt_cpol_q <= fmt_cpol_n; fmt_cpha_q <= fmt_cpha_n;
      xmode_q <= xmode_n; wcnt_q <= wcnt_n; rcnt_q <= rcnt_n;
      div_q <= div_n; ctrl_q <= ctrl_n;
    end
  end

  logic [FRAME_W-1:0] tx_dout, rx_dout, rx_din;
  logic [LVL_W-1:0]   tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push, busy;

  spi_seq_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .clr(ctrl_q[2]),
    .push(wr_data && !tx_full), .din(bus_wdata[FRAME_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty));

  spi_seq_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s), .clr(ctrl_q[1]),
    .push(rx_push), .din(rx_din),
    .pop(rd_data && !rx_empty), .dout(rx_dout), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty));

  spi_seq_engine #(.FRAME_W(FRAME_W)) u_eng (
    .clk(clk), .rst_n(rst_s),
    .start_i(wr_cmd), .abort_i(ctrl_q[0]),
    .mode_i(xmode_q), .wcnt_i(wcnt_q), .rcnt_i(rcnt_q),
    .len_i(fmt_len_q), .cpol_i(fmt_cpol_q), .cpha_i(fmt_cpha_q), .div_i(div_q),
    .tx_empty_i(tx_empty), .tx_data_i(tx_dout), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_din),
    .sclk_o(spi_sclk), .mosi_o(spi_mosi), .miso_i(spi_miso),
    .cs_n_o(spi_cs_n), .busy_o(busy));

  logic [31:0] stat_w;
  always_comb begin
    stat_w        = '0;
    stat_w[0]     = busy;
    stat_w[12:8]  = 5'(rx_lvl);
    stat_w[20:16] = 5'(tx_lvl);
    stat_w[22]    = tx_empty;
    stat_w[23]    = tx_full;
  end

  always_comb begin
    case (bus_addr)
      REG_FORMAT: bus_rdata = {19'b0, fmt_len_q, 6'b0, fmt_cpol_q, fmt_cpha_q};
      REG_XCTRL:  bus_rdata = {4'b0, xmode_q, 3'b0, wcnt_q, 3'b0, rcnt_q};
      REG_DATA:   bus_rdata = rx_empty ? 32'b0 : 32'(rx_dout);
      REG_CTRL:   bus_rdata = {29'b0, ctrl_q};
      REG_STATUS: bus_rdata = stat_w;
      REG_TIMING: bus_rdata = {24'b0, div_q};
      default:    bus_rdata = 32'b0;
    endcase
  end

  // R11: a control bit never stays set for two cycles without a fresh write
  assert_self_clear_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (ctrl_q != 3'b000 && !wr_ctrl) |=> (ctrl_q == 3'b000));

endmodule

// File: tb/spi_seq_master_test.sv
`timescale 1ns/1ps
module spi_seq_master_test;
  logic clk, rst_n, bus_wr, bus_rd, spi_miso;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic spi_sclk, spi_mosi, spi_cs_n;

  spi_seq_master uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rises = 0, cs_falls = 0, sbit = 0, fb = 8;
  time t_r0, t_r1, t_last, t_csr;
  logic [7:0] srx;
  logic [7:0] slog [0:1023];

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + 83);
  endfunction
  function automatic logic respbit(input int k, input int b);
    logic [7:0] v;
    v = resp(k);
    return v[b];
  endfunction

  // slave model, SPI mode 0
  always @(negedge spi_cs_n) begin
    sbit = 0; cs_falls++; spi_miso = respbit(0, fb - 1);
  end
  always @(posedge spi_cs_n) t_csr = $time;
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (rises == 0) t_r0 = $time;
    if (rises == 1) t_r1 = $time;
    rises++; t_last = $time;
    srx = {srx[6:0], spi_mosi}; sbit++;
    if (sbit % fb == 0 && sbit / fb <= 1024)
      slog[sbit / fb - 1] = srx & 8'((1 << fb) - 1);
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    t_last = $time;
    spi_miso = respbit(sbit / fb, fb - 1 - (sbit % fb));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #5 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic idle_wait();
    logic [31:0] s;
    s = 32'h1;
    for (int n = 0; n < 40000 && s[0]; n++) rd(8'h34, s);
  endtask
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic go(input int m, input int w, input int r);
    rises = 0; cs_falls = 0;
    wr(8'h20, (m << 24) | ((w - 1) << 12) | (r - 1));
    wr(8'h24, 32'h0);
  endtask

  logic [31:0] v;
  int bad;

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; spi_miso = 1'b0;
    cycles(3); rst_n = 1'b1; cycles(4);

    rd(8'h34, v); chk("R1 status", v, 32'h0040_0000);
    rd(8'h10, v); chk("R1 format", v, 32'h0000_0700);
    chk("R1 pins", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'h4);

    // R2 / R7 / R14: write-only sweep over the divider
    for (int d = 0; d < 4; d++) begin
      wr(8'h40, d);
      for (int j = 0; j < 3; j++) wr(8'h2C, d * 16 + j * 7 + 1);
      go(1, 3, 1); idle_wait();
      chk("R2 edges", rises, 24);
      bad = 0;
      for (int j = 0; j < 3; j++) if (slog[j] != 8'(d * 16 + j * 7 + 1)) bad++;
      chk("R2 bytes", bad, 0);
      rd(8'h34, v); chk("R2 no rx", v[12:8], 0);
      chk("R7 period", 32'(t_r1 - t_r0), 32'(2 * (d + 1) * 20));
      chk("R14 release gap", 32'(t_csr - t_last), 32'((d + 1) * 20));
    end

    // R3 read only
    wr(8'h40, 1);
    go(2, 1, 5); idle_wait();
    chk("R3 edges", rises, 40);
    bad = 0; for (int j = 0; j < 5; j++) if (slog[j] != 0) bad++;
    chk("R3 mosi low", bad, 0);
    rd(8'h34, v); chk("R3 level", v[12:8], 5);
    bad = 0; for (int j = 0; j < 5; j++) begin rd(8'h2C, v); if (v != 32'(resp(j))) bad++; end
    chk("R3 data", bad, 0);
    rd(8'h2C, v); chk("R3 empty read", v, 0);

    // R4 write then read
    wr(8'h2C, 8'hC3); wr(8'h2C, 8'h5A);
    go(3, 2, 3); idle_wait();
    chk("R4 one window", cs_falls, 1);
    chk("R4 edges", rises, 40);
    chk("R4 wbytes", {slog[0], slog[1]}, 16'hC35A);
    chk("R4 mosi low", {slog[2], slog[3], slog[4]}, 0);
    rd(8'h34, v); chk("R4 level", v[12:8], 3);
    bad = 0; for (int j = 0; j < 3; j++) begin rd(8'h2C, v); if (v != 32'(resp(2 + j))) bad++; end
    chk("R4 data", bad, 0);

    // R5 full duplex, read count ignored
    for (int j = 0; j < 4; j++) wr(8'h2C, 8'h90 + j);
    go(0, 4, 9); idle_wait();
    chk("R5 edges", rises, 32);
    bad = 0;
    for (int j = 0; j < 4; j++) begin
      if (slog[j] != 8'(8'h90 + j)) bad++;
      rd(8'h2C, v); if (v != 32'(resp(j))) bad++;
    end
    chk("R5 pairs", bad, 0);
    rd(8'h34, v); chk("R5 level", v[12:8], 0);

    // R6 no-data codes
    go(7, 1, 1); idle_wait(); cycles(10);
    chk("R6 mode7", {rises[15:0], cs_falls[15:0]}, 32'h0000_0001);
    go(12, 2, 2); idle_wait(); cycles(10);
    chk("R6 mode12", {rises[15:0], cs_falls[15:0]}, 32'h0000_0001);
    rd(8'h34, v); chk("R6 status", v, 32'h0040_0000);

    // R8 TX stall
    wr(8'h2C, 8'h11); wr(8'h2C, 8'h22);
    go(1, 4, 1); cycles(400);
    chk("R8 stalled edges", rises, 16);
    rd(8'h34, v); chk("R8 busy", v[0], 1);
    wr(8'h2C, 8'h33); wr(8'h2C, 8'h44); idle_wait();
    chk("R8 edges", rises, 32);
    chk("R8 bytes", {slog[0], slog[1], slog[2], slog[3]}, 32'h11223344);

    // R9 RX full stall
    go(2, 1, 20); cycles(1000);
    rd(8'h34, v); chk("R9 full level", {v[12:8], 7'b0, v[0]}, {5'd16, 7'b0, 1'b1});
    chk("R9 stalled edges", rises, 128);
    bad = 0; for (int j = 0; j < 16; j++) begin rd(8'h2C, v); if (v != 32'(resp(j))) bad++; end
    idle_wait();
    rd(8'h34, v); chk("R9 tail level", v[12:8], 4);
    for (int j = 16; j < 20; j++) begin rd(8'h2C, v); if (v != 32'(resp(j))) bad++; end
    chk("R9 data", bad, 0);

    // R2 upper bound: 512 bytes read while draining
    wr(8'h40, 0);
    go(2, 1, 512);
    bad = 0;
    for (int got = 0, n = 0; got < 512 && n < 30000; n++) begin
      rd(8'h34, v);
      if (v[12:8] != 0) begin rd(8'h2C, v); if (v != 32'(resp(got))) bad++; got++; end
    end
    idle_wait();
    chk("R2 512 data", bad, 0);
    chk("R2 512 edges", rises, 4096);

    // R10 TX full and dropped write
    for (int j = 0; j < 17; j++) wr(8'h2C, j * 3 + 2);
    rd(8'h34, v); chk("R10 full flags", {v[23:22], v[20:16]}, {2'b10, 5'd16});
    go(1, 16, 1); idle_wait();
    bad = 0; for (int j = 0; j < 16; j++) if (slog[j] != 8'(j * 3 + 2)) bad++;
    chk("R10 bytes", bad, 0);
    rd(8'h34, v); chk("R10 drained", v, 32'h0040_0000);

    // R11 resets
    for (int j = 0; j < 3; j++) wr(8'h2C, j);
    wr(8'h30, 4); cycles(2);
    rd(8'h34, v); chk("R11 tx flush", v[20:16], 0);
    rd(8'h30, v); chk("R11 self clear", v, 0);
    go(2, 1, 3); idle_wait();
    wr(8'h30, 2); cycles(2);
    rd(8'h34, v); chk("R11 rx flush", v[12:8], 0);
    wr(8'h2C, 8'h77); go(1, 4, 1); cycles(200);
    wr(8'h30, 1); cycles(2);
    rd(8'h34, v); chk("R11 abort", {v[0], 30'b0, spi_cs_n}, 32'h1);

    // R12 start while busy
    wr(8'h2C, 8'hAB); wr(8'h2C, 8'hCD);
    go(1, 2, 1); wr(8'h24, 0); idle_wait(); cycles(100);
    chk("R12 one frame", {rises[15:0], cs_falls[15:0]}, {16'd16, 16'd1});

    // R13 frame length and idle level
    wr(8'h10, 32'h300); fb = 4;
    wr(8'h2C, 8'hA5); wr(8'h2C, 8'h3C);
    go(0, 2, 1); idle_wait();
    chk("R13 edges", rises, 8);
    chk("R13 nibbles", {slog[0], slog[1]}, 16'h050C);
    bad = 0; for (int j = 0; j < 2; j++) begin rd(8'h2C, v); if (v != 32'(resp(j) & 8'h0F)) bad++; end
    chk("R13 rx nibbles", bad, 0);
    fb = 8;
    wr(8'h10, 32'h702); cycles(2);
    chk("R13 cpol idle", spi_sclk, 1);
    rd(8'h10, v); chk("R13 format", v, 32'h702);
    wr(8'h10, 32'h700); cycles(2);
    chk("R13 cpol back", spi_sclk, 0);

    finish_run();
  end
endmodule